// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which requester owns a shared external bus. Up to six processor nodes and one host compete for it. Each node has a request line and a lock line. The host has a single request line. One output vector names the owner with one bit, and an index output carries the same owner as a number. A mode input picks the priority scheme: fixed, where the lowest-numbered node wins, or rotating, where the search starts just after the last node that held the bus.

Ownership changes only at defined points. The owner keeps the bus while it goes on requesting. An owner node that holds its lock line high keeps the bus no matter what else requests, so that a read-modify-write sequence is never split. Without a lock, the host takes priority over the nodes. When nobody requests, the last owner stays parked on the bus. Every change of owner passes through exactly one cycle in which no grant is driven. This gap lets the old master release the bus before the new one drives it.

Top module: `busArbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `grant` is all zeros and `masterId` is 0.
- R2: At most one bit of `grant` is set. Bit i (for i below NODES) means node i owns the bus, and bit NODES means the host owns it. Whenever `grant` is nonzero, `masterId` equals the index of the set bit, so the host is reported as NODES (6 by default).
- R3: Every change of owner, including the first grant after reset, inserts exactly one cycle with `grant` all zeros. Suppose the inputs that cause the change are sampled at clock edge k. Then `grant` is zero after edge k and shows the new owner after edge k+1. Two different nonzero grant values are never seen on consecutive cycles.
- R4: A node that owns the bus keeps it while its request stays high, as long as the host is not requesting, even when other nodes request.
- R5: With `rotateMode` = 0, the lowest-numbered requesting node is chosen.
- R6: With `rotateMode` = 1, the search starts at the node after the last node that held the bus and wraps around. The last holder therefore has the lowest priority. After reset the search starts at node 0.
- R7: An owner node whose lock line is high keeps the bus. This holds even if it drops its request, and even if the host or other nodes request.
- R8: When the host requests and no lock is held, the host is chosen ahead of every node. The host then keeps the bus for as long as its request stays high.
- R9: When the owner no longer holds the bus and no one is requesting, the grant stays on the last owner (parked) and no gap cycle occurs.
- R10: The new owner is fixed when the gap cycle begins. Inputs seen during the gap cycle do not change which owner is granted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rotateMode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| nodeReq | input | NODES | Per-node bus request |
| nodeLock | input | NODES | Per-node lock; takes effect only for the current owner |
| hostReq | input | 1 | Host bus request |
| grant | output | NODES+1 | One-hot owner; bit NODES is the host |
| masterId | output | $clog2(NODES+1) | Index of the owner |

## Verification
A wrong internal state shows up at the ports within one or two cycles. A stale pending owner produces a grant to a node that does not match the priority rule, in the cycle right after the gap. A wrong last-holder index in rotating mode shows up at the next handover as a different winner. A broken phase register shows up as two owners in back-to-back cycles, or as a missing or doubled gap. The bench compares `grant` and `masterId` every cycle against a cycle-accurate model, so each of these faults fails at the first affected cycle.

// File: rtl/busArbPkg.sv
package busArbPkg;

  typedef enum logic [1:0] {
    PH_EMPTY = 2'd0,
    PH_GAP   = 2'd1,
    PH_OWNED = 2'd2
  } arbPhase_t;

  typedef struct packed {
    logic startSwitch;
    logic commit;
  } arbStrobe_t;

endpackage

// File: rtl/busArbCtrl.sv
module busArbCtrl
  import busArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdNow,
  input  logic       targetValid,
  output arbStrobe_t strobe
);

  arbPhase_t phase, phaseNext;

  always_comb begin
    phaseNext          = phase;
    strobe.startSwitch = 1'b0;
    strobe.commit      = 1'b0;
    unique case (phase)
      PH_EMPTY: begin
        if (targetValid) begin
          strobe.startSwitch = 1'b1;
          phaseNext          = PH_GAP;
        end
      end
      PH_GAP: begin
        strobe.commit = 1'b1;
        phaseNext     = PH_OWNED;
      end
      PH_OWNED: begin
        if (!holdNow && targetValid) begin
          strobe.startSwitch = 1'b1;
          phaseNext          = PH_GAP;
        end
      end
      default: phaseNext = PH_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_EMPTY;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/busArbPath.sv
module busArbPath
  import busArbPkg::*;
#(
  parameter int NODES = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             rotateMode,
  input  logic [NODES-1:0]                 nodeReq,
  input  logic [NODES-1:0]                 nodeLock,
  input  logic                             hostReq,
  input  arbStrobe_t                       strobe,
  output logic                             holdNow,
  output logic                             targetValid,
  output logic [NODES:0]                   grant,
  output logic [$clog2(NODES+1)-1:0]       masterId
);

  localparam int ID_W   = $clog2(NODES+1);
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1;
  localparam logic [ID_W-1:0] HOST_ID = ID_W'(NODES);

  logic [ID_W-1:0]   ownerId, pendId, targetId;
  logic [NODE_W-1:0] lastNode, pickId, ownerSel;
  logic [NODES:0]    grantReg;
  logic              ownerIsHost, pickFound;

  assign ownerIsHost = (ownerId == HOST_ID);
  assign ownerSel    = ownerIsHost ? '0 : ownerId[NODE_W-1:0];

  // owner keeps the bus: host while requesting; node while locked, or while requesting with no host demand
  always_comb begin
    if (ownerIsHost) holdNow = hostReq;
    else             holdNow = nodeLock[ownerSel] || (nodeReq[ownerSel] && !hostReq);
  end

  // priority search over nodes
  always_comb begin
    int idx;
    pickId    = '0;
    pickFound = 1'b0;
    idx       = 0;
    for (int i = 0; i < NODES; i++) begin
      idx = rotateMode ? ((int'(lastNode) + 1 + i) % NODES) : i;
      if (!pickFound && nodeReq[idx]) begin
        pickFound = 1'b1;
        pickId    = NODE_W'(idx);
      end
    end
  end

  assign targetValid = hostReq || pickFound;
  assign targetId    = hostReq ? HOST_ID : ID_W'(pickId);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerId  <= '0;
      pendId   <= '0;
      lastNode <= NODE_W'(NODES - 1);
      grantReg <= '0;
    end else if (strobe.startSwitch) begin
      pendId   <= targetId;
      grantReg <= '0;
    end else if (strobe.commit) begin
      ownerId  <= pendId;
      grantReg <= (NODES+1)'(1) << pendId;
      if (pendId != HOST_ID) lastNode <= pendId[NODE_W-1:0];
    end
  end

  assign grant    = grantReg;
  assign masterId = ownerId;

endmodule

// File: rtl/busArbiter.sv
module busArbiter
  import busArbPkg::*;
#(
  parameter int NODES = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rotateMode,
  input  logic [NODES-1:0]           nodeReq,
  input  logic [NODES-1:0]           nodeLock,
  input  logic                       hostReq,
  output logic [NODES:0]             grant,
  output logic [$clog2(NODES+1)-1:0] masterId
);

  arbStrobe_t strobe;
  logic       holdNow, targetValid;

  busArbCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .holdNow    (holdNow),
    .targetValid(targetValid),
    .strobe     (strobe)
  );

  busArbPath #(.NODES(NODES)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .rotateMode (rotateMode),
    .nodeReq    (nodeReq),
    .nodeLock   (nodeLock),
    .hostReq    (hostReq),
    .strobe     (strobe),
    .holdNow    (holdNow),
    .targetValid(targetValid),
    .grant      (grant),
    .masterId   (masterId)
  );

endmodule

// File: rtl/busArbiterChk.sv
module busArbiterChk #(
  parameter int NODES = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NODES-1:0]           nodeReq,
  input logic [NODES-1:0]           nodeLock,
  input logic                       hostReq,
  input logic [NODES:0]             grant,
  input logic [$clog2(NODES+1)-1:0] masterId
);

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  a_r2_id_match: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0) |-> grant[masterId]);

  a_r3_no_direct_handover: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0 && $past(grant) != '0) |-> (grant == $past(grant)));

  a_r3_single_gap: assert property (@(posedge clk) disable iff (!rstN)
    ($past(grant) != '0 && grant == '0) |=> (grant != '0));

  a_r7_lock_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (grant[NODES] == 1'b0 && (grant[NODES-1:0] & nodeLock) != '0) |=> $stable(grant));

  a_r8_host_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (grant[NODES] && hostReq) |=> grant[NODES]);

  a_r9_parked: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0 && nodeReq == '0 && !hostReq) |=> $stable(grant));

endmodule

bind busArbiter busArbiterChk #(.NODES(NODES)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .nodeReq (nodeReq),
  .nodeLock(nodeLock),
  .hostReq (hostReq),
  .grant   (grant),
  .masterId(masterId)
);

// File: tb/test_busArbiter.sv
module test_busArbiter;

  localparam int NODES  = 6;
  localparam int ID_W   = $clog2(NODES+1);
  localparam int CLK_NS = 10;

  logic             clk = 1'b0;
  logic             rstN;
  logic             rotateMode;
  logic [NODES-1:0] nodeReq, nodeLock;
  logic             hostReq;
  logic [NODES:0]   grant;
  logic [ID_W-1:0]  masterId;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // reference model state
  int             mPhase;   // 0 empty, 1 gap, 2 owned
  int             mOwner, mPend, mLast;
  logic [NODES:0] mGrant;

  always #(CLK_NS/2) clk = ~clk;

  busArbiter #(.NODES(NODES)) i_busArbiter (
    .clk(clk), .rstN(rstN), .rotateMode(rotateMode), .nodeReq(nodeReq),
    .nodeLock(nodeLock), .hostReq(hostReq), .grant(grant), .masterId(masterId)
  );

  function automatic int pickNode(logic [NODES-1:0] req, logic rot, int last);
    for (int i = 0; i < NODES; i++) begin
      int n;
      n = rot ? (last + 1 + i) % NODES : i;
      if (req[n]) return n;
    end
    return -1;
  endfunction

  function automatic int targetOf(logic [NODES-1:0] req, logic host, logic rot, int last);
    if (host) return NODES;
    return pickNode(req, rot, last);
  endfunction

  function automatic bit ownerHolds(int owner, logic [NODES-1:0] req,
                                    logic [NODES-1:0] lck, logic host);
    if (owner == NODES) return host;
    return lck[owner] || (req[owner] && !host);
  endfunction

  task automatic modelReset();
    mPhase = 0; mOwner = 0; mPend = 0; mLast = NODES - 1; mGrant = '0;
  endtask

  task automatic modelStep();
    int t;
    t = targetOf(nodeReq, hostReq, rotateMode, mLast);
    case (mPhase)
      0: if (t >= 0) begin mPend = t; mGrant = '0; mPhase = 1; end
      1: begin
           mOwner = mPend; mGrant = '0; mGrant[mPend] = 1'b1;
           if (mPend != NODES) mLast = mPend;
           mPhase = 2;
         end
      default:
        if (!ownerHolds(mOwner, nodeReq, nodeLock, hostReq) && t >= 0) begin
          mPend = t; mGrant = '0; mPhase = 1;
        end
    endcase
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareModel(string tag);
    check({tag, " grant"}, 32'(grant), 32'(mGrant));
    if (mGrant != '0) check({tag, " masterId"}, 32'(masterId), 32'(mOwner));
  endtask

  // inputs are set before the call; sampled at the next rising edge
  task automatic tick(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareModel(tag);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; rotateMode = 1'b0; nodeReq = '0; nodeLock = '0; hostReq = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    check("R1 reset grant", 32'(grant), 32'd0);
    check("R1 reset id", 32'(masterId), 32'd0);
    rstN = 1'b1;
    tick("R1 idle");
    check("R1 first cycle grant", 32'(grant), 32'd0);

    // R5 fixed priority, R3 gap from empty
    nodeReq = 6'b010100;
    tick("R3");
    check("R3 gap before first owner", 32'(grant), 32'd0);
    tick("R5");
    check("R5 lowest wins", 32'(grant), 32'b0000100);
    check("R2 id of node2", 32'(masterId), 32'd2);
    tick("R4");
    tick("R4");
    check("R4 owner retains", 32'(grant), 32'b0000100);

    // handover on release
    nodeReq = 6'b010000;
    tick("R3");
    check("R3 gap on handover", 32'(grant), 32'd0);
    tick("R3");
    check("R3 new owner node4", 32'(grant), 32'b0010000);

    // R7 lock holds against host and other nodes
    nodeLock = 6'b010000; nodeReq = 6'b000001; hostReq = 1'b1;
    for (int i = 0; i < 4; i++) tick("R7");
    check("R7 locked owner kept", 32'(grant), 32'b0010000);

    // R8 host wins once lock drops
    nodeLock = '0;
    tick("R8");
    check("R8 gap", 32'(grant), 32'd0);
    tick("R8");
    check("R8 host granted", 32'(grant), 32'b1000000);
    check("R2 host id", 32'(masterId), 32'd6);
    tick("R8"); tick("R8");
    check("R8 host keeps", 32'(grant), 32'b1000000);

    // R9 park
    hostReq = 1'b0; nodeReq = '0;
    for (int i = 0; i < 3; i++) tick("R9");
    check("R9 parked on host", 32'(grant), 32'b1000000);

    // R6 rotating: last node was 4, so node 5 first
    rotateMode = 1'b1; nodeReq = 6'b111111;
    tick("R6"); tick("R6");
    check("R6 rotate after last", 32'(grant), 32'b0100000);

    // R10: target chosen at gap start, later inputs ignored
    nodeReq = 6'b000011;
    tick("R10");
    check("R10 gap", 32'(grant), 32'd0);
    nodeReq = 6'b000010;
    tick("R10");
    check("R10 committed owner", 32'(grant), 32'b0000001);
    tick("R6"); tick("R6");
    check("R6 next node1", 32'(grant), 32'b0000010);

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      nodeReq    = NODES'($urandom) & NODES'($urandom);
      nodeLock   = (($urandom % 4) == 0) ? NODES'($urandom) : '0;
      hostReq    = (($urandom % 6) == 0);
      if (($urandom % 200) == 0) rotateMode = ~rotateMode;
      if (($urandom % 10) == 0) begin nodeReq = '0; hostReq = 1'b0; end
      tick("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule